// File: doc/BRIEF.md
# I2C Register Access Slave

This block is the bus-facing front end of a small register-mapped peripheral. It listens to an I2C bus through a system-clocked sampler and answers transactions addressed to it. The register storage lives outside the block and is reached through single-cycle write and read strobes. The block only frames the bus traffic: it spots START, repeated START and STOP, checks the device address, takes a register index, and then moves data bytes in either direction.

A transaction opens with a control byte. Its upper four bits are the fixed prefix `0100`, the next three bits must equal the three strap inputs, and the last bit selects the direction. A write sends one register-index byte and then any number of data bytes. A read first sets the index with a write, then issues a repeated START with a read control byte and clocks data out. An internal pointer moves to the next register after every byte, wraps from the last register back to the first, and can be frozen by a configuration input so that one register can be accessed over and over. The SDA pad is modelled as an input plus a pull-low enable for an open-drain driver.

Top module: `i2c_regport`

## Requirements
- R1: After reset the SDA pull-low is off and neither register strobe is active.
- R2: A control byte whose upper seven bits equal `0100` followed by `hw_addr[2:0]` (MSB first) is acknowledged by pulling SDA low in the ninth clock; bit 0 of that byte selects write (0) or read (1).
- R3: A control byte with any other address gets no acknowledge, and the slave neither drives SDA nor issues strobes until the next START.
- R4: In a write, the register-index byte and every data byte are acknowledged, and each complete data byte produces exactly one write strobe carrying the current pointer and the byte.
- R5: A data byte cut short by STOP or by a repeated START causes no write strobe, and the pointer does not move.
- R6: After a repeated START with a read control byte, the slave shifts out the register at the pointer, MSB first, changing SDA after SCL falling edges.
- R7: With `seq_hold` low, the pointer advances by one after each data byte written and after each byte fetched for reading.
- R8: With `seq_hold` high, the pointer does not move, so successive bytes all access the same register.
- R9: The pointer wraps from the last register (index NREG-1, 0x0A by default) to 0; an index byte above the last register sets the pointer to 0.
- R10: A NACK from the master after a read byte ends the read: SDA stays released and no further read strobe is issued until the next START.
- R11: The slave only changes its SDA drive while SCL is low, and write and read strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_low | output | 1 | Enable for the open-drain SDA pull-low driver |
| hw_addr | input | 3 | Address straps compared with the control byte |
| seq_hold | input | 1 | 1 freezes the register pointer |
| reg_wr_en | output | 1 | One-cycle write strobe to the register file |
| reg_rd_en | output | 1 | One-cycle read strobe to the register file |
| reg_addr | output | $clog2(NREG) | Register index for the strobe |
| reg_wdata | output | 8 | Data for a write strobe |
| reg_rdata | input | 8 | Register contents, valid the cycle after a read strobe |

## Verification
A wrong pointer shows up on the register file strobes within one byte time: a write lands at the wrong index, or the next read returns a neighbour's value, so the bench compares every register against its own model after each transaction. A wrong framing state shows as a missing or extra acknowledge on the ninth clock of the affected byte, or as a spurious write strobe after an aborted byte, both visible on the bus within the same byte. A wrong transmit shifter corrupts the read byte the master collects, and a late or early drive change is caught by watching SDA drive edges against SCL level.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  // Protocol engine states
  typedef enum logic [3:0] {
    ST_IDLE,       // no transaction in progress
    ST_CTRL,       // shifting in the control byte
    ST_CTRL_ACK,   // acknowledging the control byte
    ST_RADDR,      // shifting in the register index
    ST_RADDR_ACK,  // acknowledging the register index
    ST_WDATA,      // shifting in a data byte
    ST_WDATA_ACK,  // acknowledging a data byte
    ST_RFETCH,     // read strobe issued, waiting for the file
    ST_RLOAD,      // register data available, load shifter
    ST_RDATA,      // shifting a data byte out
    ST_RACK,       // master acknowledge slot
    ST_IGNORE      // not addressed or read ended; wait for framing
  } st_e;

endpackage

// File: rtl/i2cr_busmon.sv
module i2cr_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl,
  output logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  // line 0 = SCL, line 1 = SDA
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] now;
  logic [NLINES-1:0] prev;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] pipe;
    logic                   last;
    always_ff @(posedge clk) begin
      if (rst) begin
        pipe <= '1;
        last <= 1'b1;
      end else begin
        pipe <= {pipe[SYNC_STAGES-2:0], raw[g]};
        last <= pipe[SYNC_STAGES-1];
      end
    end
    assign now[g]  = pipe[SYNC_STAGES-1];
    assign prev[g] = last;
  end

  assign scl       = now[0];
  assign sda       = now[1];
  assign scl_rise  = now[0] & ~prev[0];
  assign scl_fall  = ~now[0] & prev[0];
  // framing events: SDA edge while SCL stays high
  assign start_det = now[0] & prev[0] & prev[1] & ~now[1];
  assign stop_det  = now[0] & prev[0] & ~prev[1] & now[1];

endmodule

// File: rtl/i2cr_ptr.sv
module i2cr_ptr #(
  parameter  int NREG = 11,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [7:0]    load_val,
  input  logic          step,
  input  logic          hold,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] LAST = AW'(NREG - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= (load_val < 8'(NREG)) ? load_val[AW-1:0] : '0;
    end else if (step && !hold) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  // R9: pointer never leaves the register range
  p_ptr_range_r9: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);

  // R9: stepping past the last register wraps to zero
  p_ptr_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (!load && step && !hold && ptr == LAST) |=> ptr == '0);

  // R8: a held pointer keeps its value across a step request
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && step && hold) |=> $stable(ptr));

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2cr_pkg::*;
#(
  parameter  int         NREG        = 11,
  parameter  int         SYNC_STAGES = 2,
  parameter  logic [3:0] DEV_PREFIX  = 4'b0100,
  localparam int         AW          = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_drive_low,
  input  logic [2:0]    hw_addr,
  input  logic          seq_hold,
  output logic          reg_wr_en,
  output logic          reg_rd_en,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  input  logic [7:0]    reg_rdata
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cr_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_i),
    .sda_in   (sda_i),
    .scl      (scl_s),
    .sda      (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  st_e        st;
  logic [2:0] bitcnt;
  logic [7:0] rx;
  logic [7:0] tx;
  logic       byte_full;
  logic       is_read;
  logic       mack;
  logic       ptr_load, ptr_step;
  logic [AW-1:0] ptr;
  logic       rx_phase;
  logic       framing;

  assign framing  = start_det | stop_det;
  assign rx_phase = (st == ST_CTRL) || (st == ST_RADDR) || (st == ST_WDATA);

  // pointer control: load on index byte, step after each data byte moved
  always_comb begin
    ptr_load = 1'b0;
    ptr_step = 1'b0;
    if (!framing && scl_fall) begin
      if (st == ST_RADDR && byte_full) ptr_load = 1'b1;
      if (st == ST_WDATA && byte_full) ptr_step = 1'b1;
      if (st == ST_CTRL_ACK && is_read) ptr_step = 1'b1;
      if (st == ST_RACK && mack)        ptr_step = 1'b1;
    end
  end

  i2cr_ptr #(.NREG(NREG)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .load    (ptr_load),
    .load_val(rx),
    .step    (ptr_step),
    .hold    (seq_hold),
    .ptr     (ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      bitcnt        <= '0;
      rx            <= '0;
      tx            <= '0;
      byte_full     <= 1'b0;
      is_read       <= 1'b0;
      mack          <= 1'b0;
      sda_drive_low <= 1'b0;
      reg_wr_en     <= 1'b0;
      reg_rd_en     <= 1'b0;
      reg_addr      <= '0;
      reg_wdata     <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      if (start_det) begin
        st            <= ST_CTRL;
        bitcnt        <= '0;
        byte_full     <= 1'b0;
        sda_drive_low <= 1'b0;
      end else if (stop_det) begin
        st            <= ST_IDLE;
        bitcnt        <= '0;
        byte_full     <= 1'b0;
        sda_drive_low <= 1'b0;
      end else begin
        if (scl_rise && rx_phase) begin
          rx     <= {rx[6:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 3'd7) byte_full <= 1'b1;
        end
        unique case (st)
          ST_CTRL: if (scl_fall && byte_full) begin
            byte_full <= 1'b0;
            if (rx[7:1] == {DEV_PREFIX, hw_addr}) begin
              is_read       <= rx[0];
              sda_drive_low <= 1'b1;
              st            <= ST_CTRL_ACK;
            end else begin
              st <= ST_IGNORE;
            end
          end
          ST_RADDR: if (scl_fall && byte_full) begin
            byte_full     <= 1'b0;
            sda_drive_low <= 1'b1;
            st            <= ST_RADDR_ACK;
          end
          ST_WDATA: if (scl_fall && byte_full) begin
            byte_full     <= 1'b0;
            reg_wr_en     <= 1'b1;
            reg_addr      <= ptr;
            reg_wdata     <= rx;
            sda_drive_low <= 1'b1;
            st            <= ST_WDATA_ACK;
          end
          ST_CTRL_ACK: if (scl_fall) begin
            sda_drive_low <= 1'b0;
            if (is_read) begin
              reg_rd_en <= 1'b1;
              reg_addr  <= ptr;
              st        <= ST_RFETCH;
            end else begin
              st <= ST_RADDR;
            end
          end
          ST_RADDR_ACK, ST_WDATA_ACK: if (scl_fall) begin
            sda_drive_low <= 1'b0;
            st            <= ST_WDATA;
          end
          ST_RFETCH: st <= ST_RLOAD;
          ST_RLOAD: begin
            sda_drive_low <= ~reg_rdata[7];
            tx            <= {reg_rdata[6:0], 1'b0};
            bitcnt        <= '0;
            st            <= ST_RDATA;
          end
          ST_RDATA: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              bitcnt        <= '0;
              sda_drive_low <= 1'b0;
              st            <= ST_RACK;
            end else begin
              sda_drive_low <= ~tx[7];
              tx            <= {tx[6:0], 1'b0};
              bitcnt        <= bitcnt + 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              if (mack) begin
                reg_rd_en <= 1'b1;
                reg_addr  <= ptr;
                st        <= ST_RFETCH;
              end else begin
                st <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: drive edges only while the sampled clock line is low
  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    (sda_drive_low != $past(sda_drive_low)) |-> !scl_s);

  // R11: strobes are exclusive
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_en && reg_rd_en));

  // R4: every committed byte is acknowledged at the same moment
  p_write_acked_r4: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> sda_drive_low);

  // R3: an unaddressed slave stays silent
  p_ignore_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IGNORE) |-> (!sda_drive_low && !reg_wr_en));

endmodule

// File: tb/tb_i2c_regport.sv
`timescale 1ns/1ps
module tb_i2c_regport;

  localparam int NREG = 11;
  localparam int AW   = $clog2(NREG);
  localparam int Q    = 10;   // quarter bit time in system clocks

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  logic          scl_m, sda_m, sda_line;
  logic          sda_drive_low;
  logic [2:0]    hw_addr;
  logic          seq_hold;
  logic          reg_wr_en, reg_rd_en;
  logic [AW-1:0] reg_addr;
  logic [7:0]    reg_wdata, reg_rdata;
  logic          mem_init;

  assign sda_line = sda_m & ~sda_drive_low;

  i2c_regport #(.NREG(NREG)) dut (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .sda_drive_low(sda_drive_low),
    .hw_addr      (hw_addr),
    .seq_hold     (seq_hold),
    .reg_wr_en    (reg_wr_en),
    .reg_rd_en    (reg_rd_en),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata)
  );

  // register file model outside the block
  logic [7:0] mem     [NREG];
  logic [7:0] exp_mem [NREG];
  int wr_cnt = 0, rd_cnt = 0;
  int n_chk = 0, n_fail = 0, glitch = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < NREG; i++) mem[i] <= 8'(8'h30 + 7 * i);
      reg_rdata <= 8'h00;
    end else begin
      if (reg_wr_en) begin
        if (int'(reg_addr) < NREG) mem[reg_addr] <= reg_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (reg_rd_en) begin
        reg_rdata <= (int'(reg_addr) < NREG) ? mem[reg_addr] : 8'hXX;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  // R11 monitor: drive edge while SCL high
  logic drv_q = 1'b0, scl_q = 1'b1;
  always @(negedge clk) begin
    if (!rst && drv_q != sda_drive_low && scl_q && scl_m) glitch++;
    drv_q <= sda_drive_low;
    scl_q <= scl_m;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < NREG; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk({req, " register file mismatches"}, bad, 0);
  endtask

  // ---------------- bus master ----------------
  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] d, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    acked = !a;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!ack);
  endtask

  function automatic logic [7:0] ctrl(input logic [2:0] pins, input bit rd);
    return {4'b0100, pins, rd};
  endfunction

  function automatic int next_ptr(input int p);
    if (seq_hold) return p;
    return (p == NREG - 1) ? 0 : p + 1;
  endfunction

  // write n bytes starting at index a; model updated from the requirements
  task automatic wr_seq(input logic [7:0] a, input int n, input logic [7:0] d [4], input string req);
    bit ok;
    int bad = 0;
    int p = (a < NREG) ? int'(a) : 0;
    int w0 = wr_cnt;
    bus_start();
    put_byte(ctrl(hw_addr, 1'b0), ok); if (!ok) bad++;
    put_byte(a, ok);                   if (!ok) bad++;
    for (int i = 0; i < n; i++) begin
      put_byte(d[i], ok); if (!ok) bad++;
      exp_mem[p] = d[i];
      p = next_ptr(p);
    end
    bus_stop();
    chk({req, " missing acknowledges"}, bad, 0);
    chk({req, " write strobes"}, wr_cnt - w0, n);
    cmp_mem(req);
  endtask

  // read n bytes starting at index a, then confirm NACK ends the read (R10)
  task automatic rd_seq(input logic [7:0] a, input int n, input string req);
    bit ok;
    int bad = 0;
    int p = (a < NREG) ? int'(a) : 0;
    int r0 = rd_cnt;
    logic [7:0] q;
    bus_start();
    put_byte(ctrl(hw_addr, 1'b0), ok); if (!ok) bad++;
    put_byte(a, ok);                   if (!ok) bad++;
    bus_start();
    put_byte(ctrl(hw_addr, 1'b1), ok); if (!ok) bad++;
    for (int i = 0; i < n; i++) begin
      get_byte(q, i != n - 1);
      chk({req, " read data"}, q, exp_mem[p]);
      p = next_ptr(p);
    end
    chk({req, " missing acknowledges"}, bad, 0);
    chk("R10 SDA released after NACK", sda_drive_low, 0);
    get_byte(q, 1'b0);
    chk("R10 bus idle after NACK", q, 8'hFF);
    chk("R10 no fetch after NACK", rd_cnt - r0, n);
    bus_stop();
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 SDA released", sda_drive_low, 0);
    chk("R1 write strobe idle", reg_wr_en, 0);
    chk("R1 read strobe idle", reg_rd_en, 0);
  endtask

  task automatic t_seq_write();   // R2 R4 R7
    wr_seq(8'h02, 3, '{8'h11, 8'h22, 8'h33, 8'h00}, "R4 R7 sequential write");
  endtask

  task automatic t_seq_read();    // R6 R7
    rd_seq(8'h02, 3, "R6 R7 sequential read");
  endtask

  task automatic t_alt_pins();    // R2 with a different strap value
    hw_addr = 3'b010;
    wr_seq(8'h05, 1, '{8'h5A, 8'h00, 8'h00, 8'h00}, "R2 straps 010 write");
    rd_seq(8'h05, 1, "R2 straps 010 read");
    hw_addr = 3'b101;
  endtask

  task automatic t_wrap();        // R9
    wr_seq(8'h09, 3, '{8'h91, 8'h92, 8'h93, 8'h00}, "R9 wrap write");
    rd_seq(8'h0A, 2, "R9 wrap read");
    wr_seq(8'h0F, 1, '{8'h77, 8'h00, 8'h00, 8'h00}, "R9 out of range index");
  endtask

  task automatic t_hold();        // R8
    seq_hold = 1'b1;
    wr_seq(8'h06, 2, '{8'h61, 8'h62, 8'h00, 8'h00}, "R8 held write");
    chk("R8 neighbour untouched", mem[7], exp_mem[7]);
    rd_seq(8'h06, 2, "R8 held read");
    seq_hold = 1'b0;
  endtask

  task automatic t_mismatch();    // R3
    bit ok;
    logic [7:0] q;
    int w0 = wr_cnt, r0 = rd_cnt;
    bus_start();
    put_byte(ctrl(3'b010, 1'b0), ok);
    chk("R3 foreign write address not acknowledged", ok, 0);
    put_byte(8'h00, ok);
    chk("R3 index byte ignored", ok, 0);
    put_byte(8'hEE, ok);
    chk("R3 data byte ignored", ok, 0);
    bus_stop();
    chk("R3 no write strobe", wr_cnt - w0, 0);
    cmp_mem("R3");
    bus_start();
    put_byte(ctrl(3'b100, 1'b1), ok);
    chk("R3 foreign read address not acknowledged", ok, 0);
    get_byte(q, 1'b0);
    chk("R3 SDA left released", q, 8'hFF);
    chk("R3 no read strobe", rd_cnt - r0, 0);
    bus_stop();
  endtask

  task automatic t_abort();       // R5
    bit ok;
    int bad = 0;
    int w0 = wr_cnt;
    logic [7:0] q;
    bus_start();
    put_byte(ctrl(hw_addr, 1'b0), ok); if (!ok) bad++;
    put_byte(8'h01, ok);               if (!ok) bad++;
    put_byte(8'h55, ok);               if (!ok) bad++;
    exp_mem[1] = 8'h55;
    for (int i = 0; i < 4; i++) put_bit(i[0]);
    bus_stop();
    chk("R5 acknowledges before STOP abort", bad, 0);
    chk("R5 STOP abort write strobes", wr_cnt - w0, 1);
    cmp_mem("R5 STOP abort");
    // partial byte cut by repeated START, then read the same index
    w0 = wr_cnt;
    bus_start();
    put_byte(ctrl(hw_addr, 1'b0), ok); if (!ok) bad++;
    put_byte(8'h07, ok);               if (!ok) bad++;
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    bus_start();
    put_byte(ctrl(hw_addr, 1'b1), ok); if (!ok) bad++;
    get_byte(q, 1'b0);
    bus_stop();
    chk("R5 acknowledges around RESTART abort", bad, 0);
    chk("R5 RESTART abort write strobes", wr_cnt - w0, 0);
    chk("R5 pointer unmoved after abort", q, exp_mem[7]);
  endtask

  initial begin
    rst = 1'b1; mem_init = 1'b1;
    scl_m = 1'b1; sda_m = 1'b1;
    hw_addr = 3'b101; seq_hold = 1'b0;
    for (int i = 0; i < NREG; i++) exp_mem[i] = 8'(8'h30 + 7 * i);
    repeat (5) @(posedge clk);
    #1;
    rst = 1'b0; mem_init = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_seq_write();
    t_seq_read();
    t_alt_pins();
    t_wrap();
    t_hold();
    t_mismatch();
    t_abort();
    chk("R11 drive edges while SCL high", glitch, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule